// File: doc/BRIEF.md
# SD Card Clock Setting Search Engine

This block works out how a host should divide its base clock to drive an SD card clock. It takes a base frequency and a target frequency, both as 32-bit integers in hertz. It then searches for a prescaler and divisor pair whose combined division gives the highest achievable card clock that does not exceed the target. The prescaler moves through power-of-two steps from divide-by-2 up to divide-by-256. The divisor is a linear count from 1 up to a parameterised maximum. The search has two greedy phases. The first phase raises the prescaler for as long as even the largest divisor would leave the clock above the target. The second phase then raises the divisor one step at a time until the result falls to or below the target.

Around the search the block runs the safe reconfiguration sequence. It gates the card clock off first. It loads the newly chosen codes. It waits for the external clock-stable indication and only then turns the card clock back on. A request can also ask for the clock to be switched off. In that case the sequence stops straight after gating. Every division is done by a shared iterative restoring divider, so the block has no wide combinational dividers. The block does not generate the divided clock itself. It only supplies the codes and the enable that a clock generator consumes.

Top module: `sdclk_search`

## Requirements
- R1: Reset state: `pre_code` = 8'h80 (divide by 256), `div_code` = 0, `card_clk_en` = 0, `busy` = 0, `done` = 0. A start pulse sampled while `busy` is low is accepted. `card_clk_en` is low two cycles after that start pulse and stays low until the clock-stable step.
- R2: If the request's `en_req` is 0, the sequence finishes with a `done` pulse right after gating. `card_clk_en` stays 0. `pre_code`, `div_code`, `achieved_hz` and `err` keep their previous values.
- R3: The prescaler code is one-hot. Bit i selects division by 2^(i+1), so 8'h01 means /2 and 8'h80 means /256. The search starts at /2. It doubles the prescaler while floor(base / (prescaler × DIV_MAX)) > target and the prescaler is below /256.
- R4: `div_code` is the divisor minus one, with DIV_MAX = 16 by default. The divisor starts at 1. It increments while floor(base / (prescaler × divisor)) > target and the divisor is below DIV_MAX.
- R5: `achieved_hz` = floor(base / (prescaler × divisor)) for the chosen pair, using truncating integer division.
- R6: New codes are loaded before the wait step. `card_clk_en` rises only in the cycle after `clk_stable` has been sampled high. While `clk_stable` stays low, the block stays busy with the clock off.
- R7: A target of 0 skips the search. It loads /2 (8'h01) and divisor 1 (code 0), reports `achieved_hz` = 0 and sets `err`.
- R8: `err` is 1 exactly when the achieved frequency is 0 or exceeds the target. Otherwise it is 0.
- R9: A start pulse while `busy` is high is ignored. The running request completes with its own result and with a single `done` pulse.
- R10: `busy` is high from the cycle after an accepted start until the end of the one-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| en_req | input | 1 | 1 = configure and enable the card clock, 0 = gate it off only |
| base_hz | input | 32 | Base clock frequency in Hz |
| target_hz | input | 32 | Requested card clock frequency in Hz |
| clk_stable | input | 1 | External indication that the divided clock has settled |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Achieved frequency is zero or above the target |
| pre_code | output | 8 | One-hot prescaler code |
| div_code | output | 4 | Divisor minus one |
| achieved_hz | output | 32 | Resulting card clock frequency in Hz |
| card_clk_en | output | 1 | Card clock enable |

## Verification
The hardest condition to reach from the ports is the wait-for-stable window. It only exists after a full search and load have finished, and its length is set by the search itself. The bench holds `clk_stable` low before issuing a request. It then waits well past the longest possible search and confirms that the block is still busy with the clock gated. Only after that does it release `clk_stable` and watch the enable rise. A second hard case is a start pulse that lands in the middle of an iterative division. The bench fires one a few cycles into a run and checks that neither the codes nor the `done` count show its parameters.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_GATE,
      S_P1_REQ,
      S_P1_WAIT,
      S_P2_REQ,
      S_P2_WAIT,
      S_LOAD,
      S_STAB,
      S_FIN
   } sdclk_state_e;
endpackage

// File: rtl/sdclk_divu.sv
module sdclk_divu #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         ready,
   output logic [W-1:0] quo
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q;
   logic [W-1:0]  den_q;
   logic [W-1:0]  num_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W:0]    trial;

   generate
      if (W < 2) begin : g_bad_w
         $error("sdclk_divu: W must be at least 2");
      end
   endgenerate

   assign trial = {rem_q, quo[W-1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         den_q <= '0;
         num_q <= '0;
         quo   <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         ready <= 1'b0;
      end else begin
         ready <= 1'b0;
         if (go) begin
            rem_q <= '0;
            quo   <= num;
            num_q <= num;
            den_q <= den;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (trial >= {1'b0, den_q}) begin
               rem_q <= W'(trial - {1'b0, den_q});
               quo   <= {quo[W-2:0], 1'b1};
            end else begin
               rem_q <= trial[W-1:0];
               quo   <= {quo[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               ready <= 1'b1;
            end
         end
      end
   end

   // R5: the delivered quotient is the truncated one
   assert_quotient_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (({{W{1'b0}}, quo} * {{W{1'b0}}, den_q}) <= {{W{1'b0}}, num_q}) &&
                ({{W{1'b0}}, num_q} < ({{W{1'b0}}, quo} + 1'b1) * {{W{1'b0}}, den_q}));

   assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);
endmodule

// File: rtl/sdclk_code.sv
module sdclk_code #(
   parameter int PRE_STEPS = 8,
   parameter int DIV_MAX   = 16,
   localparam int KW  = $clog2(PRE_STEPS + 1),
   localparam int DNW = $clog2(DIV_MAX + 1),
   localparam int DCW = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1
) (
   input  logic [KW-1:0]        shift,
   input  logic [DNW-1:0]       divisor,
   output logic [PRE_STEPS-1:0] pre_code,
   output logic [DCW-1:0]       div_code
);
   genvar i;
   generate
      for (i = 0; i < PRE_STEPS; i++) begin : g_onehot
         assign pre_code[i] = (shift == KW'(i + 1));
      end
   endgenerate

   assign div_code = DCW'(divisor - 1'b1);

   // R3: a legal shift always yields exactly one prescaler bit
   always_comb begin
      if (shift >= KW'(1) && shift <= KW'(PRE_STEPS))
         assert_code_onehot_R3: assert ($countones(pre_code) == 1);
   end
endmodule

// File: rtl/sdclk_search.sv
module sdclk_search
   import sdclk_pkg::*;
#(
   parameter int FW        = 32,
   parameter int PRE_STEPS = 8,
   parameter int DIV_MAX   = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         en_req,
   input  logic [31:0]  base_hz,
   input  logic [31:0]  target_hz,
   input  logic         clk_stable,
   output logic         busy,
   output logic         done,
   output logic         err,
   output logic [7:0]   pre_code,
   output logic [3:0]   div_code,
   output logic [31:0]  achieved_hz,
   output logic         card_clk_en
);
   localparam int KW  = $clog2(PRE_STEPS + 1);
   localparam int DNW = $clog2(DIV_MAX + 1);
   localparam int DCW = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

   generate
      if (FW != 32) begin : g_bad_fw
         $error("sdclk_search: ports carry 32-bit frequencies");
      end
      if (PRE_STEPS != 8 || DCW != 4) begin : g_bad_codes
         $error("sdclk_search: port widths fix 8 prescaler steps and a 4-bit divisor code");
      end
      if (DIV_MAX < 2) begin : g_bad_div
         $error("sdclk_search: DIV_MAX must be at least 2");
      end
   endgenerate

   sdclk_state_e         state;
   logic [FW-1:0]        base_r, tgt_r, ach_r;
   logic                 en_r;
   logic [KW-1:0]        k_r;
   logic [DNW-1:0]       d_r;
   logic                 div_go, div_ready;
   logic [FW-1:0]        div_num, div_den, div_q;
   logic [PRE_STEPS-1:0] pre_next;
   logic [DCW-1:0]       dcode_next;

   assign div_go  = (state == S_P1_REQ) || (state == S_P2_REQ);
   assign div_num = base_r >> k_r;
   assign div_den = (state == S_P1_REQ || state == S_P1_WAIT) ? FW'(DIV_MAX) : FW'(d_r);
   assign busy    = (state != S_IDLE);
   assign done    = (state == S_FIN);

   sdclk_divu #(.W(FW)) divu_i (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .num   (div_num),
      .den   (div_den),
      .ready (div_ready),
      .quo   (div_q)
   );

   sdclk_code #(.PRE_STEPS(PRE_STEPS), .DIV_MAX(DIV_MAX)) code_i (
      .shift    (k_r),
      .divisor  (d_r),
      .pre_code (pre_next),
      .div_code (dcode_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         base_r      <= '0;
         tgt_r       <= '0;
         ach_r       <= '0;
         en_r        <= 1'b0;
         k_r         <= KW'(1);
         d_r         <= DNW'(1);
         err         <= 1'b0;
         pre_code    <= 8'h80;
         div_code    <= '0;
         achieved_hz <= '0;
         card_clk_en <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: begin
               if (start) begin
                  base_r <= base_hz;
                  tgt_r  <= target_hz;
                  en_r   <= en_req;
                  state  <= S_GATE;
               end
            end
            S_GATE: begin
               card_clk_en <= 1'b0;
               k_r         <= KW'(1);
               d_r         <= DNW'(1);
               if (!en_r) begin
                  state <= S_FIN;
               end else if (tgt_r == '0) begin
                  ach_r <= '0;
                  state <= S_LOAD;
               end else begin
                  state <= S_P1_REQ;
               end
            end
            S_P1_REQ: state <= S_P1_WAIT;
            S_P1_WAIT: begin
               if (div_ready) begin
                  if (div_q > tgt_r && k_r < KW'(PRE_STEPS)) begin
                     k_r   <= k_r + 1'b1;
                     state <= S_P1_REQ;
                  end else begin
                     state <= S_P2_REQ;
                  end
               end
            end
            S_P2_REQ: state <= S_P2_WAIT;
            S_P2_WAIT: begin
               if (div_ready) begin
                  if (div_q > tgt_r && d_r < DNW'(DIV_MAX)) begin
                     d_r   <= d_r + 1'b1;
                     state <= S_P2_REQ;
                  end else begin
                     ach_r <= div_q;
                     state <= S_LOAD;
                  end
               end
            end
            S_LOAD: begin
               pre_code    <= pre_next;
               div_code    <= dcode_next;
               achieved_hz <= ach_r;
               err         <= (ach_r == '0) || (ach_r > tgt_r);
               state       <= S_STAB;
            end
            S_STAB: begin
               if (clk_stable) begin
                  card_clk_en <= 1'b1;
                  state       <= S_FIN;
               end
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assert_gate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_GATE) |=> !card_clk_en);

   assert_disabled_stays_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !en_r) |-> !card_clk_en);

   assert_pre_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pre_code) == 1);

   assert_div_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (d_r >= DNW'(1)) && (d_r <= DNW'(DIV_MAX)));

   assert_enable_after_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_clk_en) |-> $past(clk_stable));

   assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && en_r) |-> (err == ((achieved_hz == '0) || (achieved_hz > tgt_r))));

   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (state != S_GATE));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/sdclk_search_tb.sv
module sdclk_search_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        en_req = 1'b0;
   logic [31:0] base_hz = '0;
   logic [31:0] target_hz = '0;
   logic        clk_stable = 1'b1;
   logic        busy, done, err, card_clk_en;
   logic [7:0]  pre_code;
   logic [3:0]  div_code;
   logic [31:0] achieved_hz;

   int n_chk = 0;
   int n_fail = 0;
   int n_done = 0;

   always #4 clk = ~clk;

   sdclk_search dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .en_req(en_req),
      .base_hz(base_hz), .target_hz(target_hz), .clk_stable(clk_stable),
      .busy(busy), .done(done), .err(err), .pre_code(pre_code),
      .div_code(div_code), .achieved_hz(achieved_hz), .card_clk_en(card_clk_en)
   );

   always @(negedge clk) if (rst_n && done) n_done++;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected pair from the requirement formulas
   task automatic model(input longint b, input longint t,
                        output int ek, output int ed, output longint ea);
      ek = 1; ed = 1; ea = 0;
      if (t == 0) return;
      while ((b / ((64'd1 << ek) * 16)) > t && ek < 8) ek++;
      while ((b / ((64'd1 << ek) * ed)) > t && ed < 16) ed++;
      ea = b / ((64'd1 << ek) * ed);
   endtask

   task automatic pulse_start(input logic [31:0] b, input logic [31:0] t, input logic e);
      @(negedge clk);
      base_hz = b; target_hz = t; en_req = e; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(done, req, 0, 1);
   endtask

   task automatic run_cfg(input logic [31:0] b, input logic [31:0] t, input string req);
      int ek, ed;
      longint ea;
      model(b, t, ek, ed, ea);
      pulse_start(b, t, 1'b1);
      @(negedge clk);
      chk(card_clk_en == 1'b0 && busy, "R1 gated after start", card_clk_en, 0);
      wait_done(req);
      chk(pre_code == 8'(1 << (ek - 1)), {req, " R3 prescaler"}, pre_code, 1 << (ek - 1));
      chk(div_code == 4'(ed - 1), {req, " R4 divisor"}, div_code, ed - 1);
      chk(achieved_hz == 32'(ea), {req, " R5 achieved"}, achieved_hz, ea);
      chk(err == (ea == 0 || ea > t), {req, " R8 err"}, err, (ea == 0 || ea > t));
      @(negedge clk);
      chk(!busy && !done && card_clk_en, {req, " R10 idle after done"}, {busy, done, card_clk_en}, 3'b001);
   endtask

   task automatic t_reset;
      chk(pre_code == 8'h80 && div_code == 0, "R1 reset codes", {pre_code, div_code}, 12'h800);
      chk(!card_clk_en && !busy && !done, "R1 reset flags", {card_clk_en, busy, done}, 0);
   endtask

   task automatic t_disable;
      logic [7:0] p0; logic [3:0] d0; logic [31:0] a0; logic e0;
      p0 = pre_code; d0 = div_code; a0 = achieved_hz; e0 = err;
      pulse_start(32'd50_000_000, 32'd1_000_000, 1'b0);
      wait_done("R2 done");
      chk(!card_clk_en, "R2 clock off", card_clk_en, 0);
      chk(pre_code == p0 && div_code == d0, "R2 codes held", {pre_code, div_code}, {p0, d0});
      chk(achieved_hz == a0 && err == e0, "R2 result held", achieved_hz, a0);
   endtask

   task automatic t_zero_target;
      pulse_start(32'd96_000_000, 32'd0, 1'b1);
      wait_done("R7 done");
      chk(pre_code == 8'h01 && div_code == 0, "R7 initial codes", {pre_code, div_code}, 12'h010);
      chk(achieved_hz == 0 && err, "R7 zero and err", {achieved_hz, err}, 1);
      @(negedge clk);
   endtask

   task automatic t_stable_wait;
      clk_stable = 1'b0;
      pulse_start(32'd96_000_000, 32'd400_000, 1'b1);
      repeat (2000) @(negedge clk);
      chk(busy && !card_clk_en, "R6 held while unstable", {busy, card_clk_en}, 2'b10);
      chk(pre_code == 8'h08 && div_code == 4'he, "R6 codes loaded before enable", {pre_code, div_code}, 12'h08e);
      clk_stable = 1'b1;
      @(negedge clk);
      chk(card_clk_en && done, "R6 enable after stable", {card_clk_en, done}, 2'b11);
      @(negedge clk);
   endtask

   task automatic t_busy_start;
      int d0;
      d0 = n_done;
      pulse_start(32'd96_000_000, 32'd25_000_000, 1'b1);
      repeat (5) @(negedge clk);
      start = 1'b1; base_hz = 32'd10; target_hz = 32'd1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R9 done");
      chk(pre_code == 8'h01 && div_code == 4'h1 && achieved_hz == 32'd24_000_000,
          "R9 first request wins", achieved_hz, 24_000_000);
      repeat (300) @(negedge clk);
      chk(n_done - d0 == 1, "R9 single done", n_done - d0, 1);
      chk(!busy, "R10 idle", busy, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_cfg(32'd96_000_000, 32'd25_000_000, "R4 25M");
      run_cfg(32'd96_000_000, 32'd400_000, "R3 400k");
      t_disable();
      run_cfg(32'd96_000_000, 32'd1_000, "R8 below reach");
      run_cfg(32'd1, 32'd5, "R8 zero result");
      run_cfg(32'd10, 32'd1, "R5 small base");
      run_cfg(32'd50_000_000, 32'd50_000_000, "R3 equal target");
      run_cfg(32'hFFFF_FFFF, 32'd3_000_000, "R5 full range");
      t_zero_target();
      t_stable_wait();
      t_busy_start();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule